// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a shared memory that two independent ports reach at the same time. Each port presents a chip enable, an address and a write strobe. When both ports are enabled on the same address, the block chooses one port as the owner of that location. It then drives an active-low busy flag to the other port and withholds that port's write permit. The memory array itself is outside the block. Its write enable is taken from the per-port write-permit outputs.

A mode input selects how the block works. In master mode it arbitrates by itself on a first-come basis. A port whose enabled access at an unchanged address was already present in the previous cycle beats a port that arrives later. When both ports arrive in the same cycle, the left port wins. In slave mode no local arbitration takes place. The busy flags come from an external master through the busy inputs, and each port's write is gated on its incoming busy having been inactive for two consecutive samples. Several devices can therefore share one arbitration result when words are wider than one device.

Top module: `dp_busy_arb`

## Requirements
- R1: In master mode a busy output (active low, 0 = busy) goes low only in the cycle after a clock edge at which both chip enables were high and both addresses were equal. An enabled pair with differing addresses, or a match with one enable low, leaves both flags high.
- R2: When a new match forms, the port whose access (enable high, same address) was already held at the previous clock edge wins. The other port alone receives busy, one clock after the match is sampled.
- R3: When neither port, or both ports, held their access at the previous edge, the left port wins and only the right busy goes low.
- R4: Busy returns high one clock after an edge at which the addresses differ or either enable is low.
- R5: A chip enable that rises while the addresses already match raises busy on the port whose enable rose, provided the other port's access was held.
- R6: Once an owner is chosen, it is kept while the match lasts, even if both addresses move together to a new common value.
- R7: In master mode a port's write permit equals its write strobe ANDed with its own busy being high. The losing port's write is dropped and the winner's write passes.
- R8: In slave mode (mode input 0) each busy output follows the matching busy input, and no local owner is recorded.
- R9: In slave mode a port's write permit is high only when its write strobe is high and its busy input is high both now and at the previous clock edge. Right after busy is released, one more edge must pass before a write is allowed.
- R10: While reset is low, and directly after it, both busy outputs are high and no owner is held. Asserting reset in the middle of operation releases a busy flag at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (local arbitration), 0 = slave (external busy) |
| l_ce_i | input | 1 | Left chip enable, active high |
| l_addr_i | input | ADDR_W | Left address |
| l_we_i | input | 1 | Left write strobe, active high |
| r_ce_i | input | 1 | Right chip enable, active high |
| r_addr_i | input | ADDR_W | Right address |
| r_we_i | input | 1 | Right write strobe, active high |
| l_busy_ni | input | 1 | External busy for the left port in slave mode, active low |
| r_busy_ni | input | 1 | External busy for the right port in slave mode, active low |
| l_busy_no | output | 1 | Busy to the left port, active low |
| r_busy_no | output | 1 | Busy to the right port, active low |
| l_wr_ok_o | output | 1 | Left write permit |
| r_wr_ok_o | output | 1 | Right write permit |

## Verification
The bench builds the block with ADDR_W = 4, so that equal and unequal address pairs, moves to a new common address and re-arrival at an old one all fit inside a short vector table. With a narrow address, the same settled address can be revisited while the enables toggle. The bench can then separate a held access from a fresh one, covering both first-come orders, the same-cycle tie and the ownership hold. Directed steps then look between clock edges to expose the one-edge settle delay in slave mode, and the asynchronous release of busy when reset is asserted.

// File: rtl/dp_arb_pkg.sv
package dp_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int NPORT = 2;
  localparam int LEFT  = 0;
  localparam int RIGHT = 1;
endpackage

// File: rtl/dp_arb_track.sv
// Flags an access whose enable and address were already present at the previous edge.
module dp_arb_track #(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              held_o
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q   <= ce_i;
      addr_q <= addr_i;
    end
  end

  assign held_o = ce_i & ce_q & (addr_q == addr_i);
endmodule

// File: rtl/dp_arb_core.sv
module dp_arb_core
  import dp_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic match_i,
  input  logic l_held_i,
  input  logic r_held_i,
  output logic l_busy_no,
  output logic r_busy_no
);
  owner_e owner_q, owner_d;

  always_comb begin
    owner_d = owner_q;
    if (!master_i || !match_i) begin
      owner_d = OWN_NONE;
    end else if (owner_q == OWN_NONE) begin
      // earlier established access wins; tie goes left
      if (r_held_i && !l_held_i) owner_d = OWN_RIGHT;
      else                       owner_d = OWN_LEFT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_NONE;
    else         owner_q <= owner_d;
  end

  assign l_busy_no = (owner_q != OWN_RIGHT);
  assign r_busy_no = (owner_q != OWN_LEFT);

  // R1
  busy_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_busy_no || !r_busy_no) |-> $past(match_i && master_i));

  // R2
  busy_one_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_busy_no || r_busy_no));

  // R4
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_i |=> (l_busy_no && r_busy_no));

  // R6
  owner_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(master_i && match_i && owner_q != OWN_NONE) |-> (owner_q == $past(owner_q)));
endmodule

// File: rtl/dp_arb_gate.sv
// Per-port busy select and write permit.
module dp_arb_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic we_i,
  input  logic arb_busy_ni,
  input  logic ext_busy_ni,
  output logic busy_no,
  output logic wr_ok_o
);
  logic ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b1;
    else         ext_q <= ext_busy_ni;
  end

  assign busy_no = master_i ? arb_busy_ni : ext_busy_ni;
  // slave: busy must read inactive at this and the previous edge
  assign wr_ok_o = we_i & (master_i ? arb_busy_ni : (ext_busy_ni & ext_q));

  // R7
  loser_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !busy_no) |-> !wr_ok_o);

  // R9
  slave_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && $past(!ext_busy_ni)) |-> !wr_ok_o);
endmodule

// File: rtl/dp_busy_arb.sv
module dp_busy_arb
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_ce_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_we_i,
  input  logic              r_ce_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_we_i,
  input  logic              l_busy_ni,
  input  logic              r_busy_ni,
  output logic              l_busy_no,
  output logic              r_busy_no,
  output logic              l_wr_ok_o,
  output logic              r_wr_ok_o
);
  logic [NPORT-1:0]  ce_v, we_v, ext_v, held_v, arb_bn, bn_v, ok_v;
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic              match;

  assign ce_v          = {r_ce_i, l_ce_i};
  assign we_v          = {r_we_i, l_we_i};
  assign ext_v         = {r_busy_ni, l_busy_ni};
  assign addr_v[LEFT]  = l_addr_i;
  assign addr_v[RIGHT] = r_addr_i;

  assign match = ce_v[LEFT] & ce_v[RIGHT] & (addr_v[LEFT] == addr_v[RIGHT]);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dp_arb_track #(.ADDR_W(ADDR_W)) u_track (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ce_i   (ce_v[p]),
      .addr_i (addr_v[p]),
      .held_o (held_v[p])
    );

    dp_arb_gate u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .master_i    (master_i),
      .we_i        (we_v[p]),
      .arb_busy_ni (arb_bn[p]),
      .ext_busy_ni (ext_v[p]),
      .busy_no     (bn_v[p]),
      .wr_ok_o     (ok_v[p])
    );
  end

  dp_arb_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .master_i  (master_i),
    .match_i   (match),
    .l_held_i  (held_v[LEFT]),
    .r_held_i  (held_v[RIGHT]),
    .l_busy_no (arb_bn[LEFT]),
    .r_busy_no (arb_bn[RIGHT])
  );

  assign l_busy_no = bn_v[LEFT];
  assign r_busy_no = bn_v[RIGHT];
  assign l_wr_ok_o = ok_v[LEFT];
  assign r_wr_ok_o = ok_v[RIGHT];

  // R8
  slave_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_no == l_busy_ni && r_busy_no == r_busy_ni));

  // R10
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (arb_bn == 2'b11));
endmodule

// File: tb/dp_busy_arb_test.sv
`timescale 1ns/1ps
module dp_busy_arb_test;
  localparam int AW = 4;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master, l_ce, l_we, r_ce, r_we, l_bi, r_bi;
  logic [AW-1:0] l_addr, r_addr;
  logic l_bo, r_bo, l_ok, r_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dp_busy_arb #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .l_ce_i(l_ce), .l_addr_i(l_addr), .l_we_i(l_we),
    .r_ce_i(r_ce), .r_addr_i(r_addr), .r_we_i(r_we),
    .l_busy_ni(l_bi), .r_busy_ni(r_bi),
    .l_busy_no(l_bo), .r_busy_no(r_bo),
    .l_wr_ok_o(l_ok), .r_wr_ok_o(r_ok)
  );

  // {req[4], mode, lce, laddr[4], lwe, rce, raddr[4], rwe, lbi, rbi, exp lbusy, rbusy, lok, rok}
  localparam logic [22:0] VEC [NV] = '{
    {4'd10, 1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'b1110}, // R10 idle
    {4'd1,  1'b1, 1'b1, 4'd5, 1'b0, 1'b1, 4'd3, 1'b1, 1'b1, 1'b1, 4'b1101}, // R1 differ
    {4'd2,  1'b1, 1'b1, 4'd5, 1'b0, 1'b1, 4'd5, 1'b1, 1'b1, 1'b1, 4'b1000}, // R2 left first
    {4'd7,  1'b1, 1'b1, 4'd5, 1'b1, 1'b1, 4'd5, 1'b1, 1'b1, 1'b1, 4'b1010}, // R7 loser dropped
    {4'd4,  1'b1, 1'b1, 4'd5, 1'b0, 1'b1, 4'd6, 1'b1, 1'b1, 1'b1, 4'b1101}, // R4 addr split
    {4'd1,  1'b1, 1'b0, 4'd5, 1'b0, 1'b1, 4'd5, 1'b0, 1'b1, 1'b1, 4'b1100}, // R1 one ce low
    {4'd2,  1'b1, 1'b1, 4'd5, 1'b1, 1'b1, 4'd5, 1'b0, 1'b1, 1'b1, 4'b0100}, // R2 right first
    {4'd6,  1'b1, 1'b1, 4'd2, 1'b1, 1'b1, 4'd2, 1'b1, 1'b1, 1'b1, 4'b0101}, // R6 hold on move
    {4'd4,  1'b1, 1'b1, 4'd2, 1'b0, 1'b0, 4'd2, 1'b0, 1'b1, 1'b1, 4'b1100}, // R4 ce drop
    {4'd1,  1'b1, 1'b0, 4'd2, 1'b0, 1'b0, 4'd2, 1'b0, 1'b1, 1'b1, 4'b1100}, // R1 both off
    {4'd3,  1'b1, 1'b1, 4'd9, 1'b0, 1'b1, 4'd9, 1'b0, 1'b1, 1'b1, 4'b1000}, // R3 same cycle
    {4'd4,  1'b1, 1'b1, 4'd9, 1'b0, 1'b0, 4'd9, 1'b0, 1'b1, 1'b1, 4'b1100}, // R4 right ce off
    {4'd5,  1'b1, 1'b1, 4'd9, 1'b0, 1'b1, 4'd9, 1'b1, 1'b1, 1'b1, 4'b1000}, // R5 ce arrival
    {4'd8,  1'b0, 1'b1, 4'd9, 1'b1, 1'b1, 4'd9, 1'b1, 1'b0, 1'b1, 4'b0101}, // R8 slave follow
    {4'd8,  1'b0, 1'b1, 4'd9, 1'b1, 1'b1, 4'd9, 1'b1, 1'b1, 1'b0, 4'b1010}, // R8 slave follow
    {4'd3,  1'b1, 1'b1, 4'd9, 1'b0, 1'b1, 4'd9, 1'b0, 1'b1, 1'b1, 4'b1000}  // R3 both held
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [3:0] exp);
    check(req, "l_busy", l_bo, exp[3]);
    check(req, "r_busy", r_bo, exp[2]);
    check(req, "l_wr_ok", l_ok, exp[1]);
    check(req, "r_wr_ok", r_ok, exp[0]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    master = 1'b1; l_ce = 1'b0; r_ce = 1'b0; l_we = 1'b1; r_we = 1'b0;
    l_addr = '0; r_addr = '0; l_bi = 1'b1; r_bi = 1'b1;
    #1;
    check_all("R10", 4'b1110);  // R10 during reset
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      master = VEC[i][18];
      l_ce = VEC[i][17]; l_addr = VEC[i][16:13]; l_we = VEC[i][12];
      r_ce = VEC[i][11]; r_addr = VEC[i][10:7];  r_we = VEC[i][6];
      l_bi = VEC[i][5];  r_bi = VEC[i][4];
      @(posedge clk); #1;
      check($sformatf("R%0d", VEC[i][22:19]), $sformatf("vec%0d l_busy", i), l_bo, VEC[i][3]);
      check($sformatf("R%0d", VEC[i][22:19]), $sformatf("vec%0d r_busy", i), r_bo, VEC[i][2]);
      check($sformatf("R%0d", VEC[i][22:19]), $sformatf("vec%0d l_wr_ok", i), l_ok, VEC[i][1]);
      check($sformatf("R%0d", VEC[i][22:19]), $sformatf("vec%0d r_wr_ok", i), r_ok, VEC[i][0]);
    end

    // R9: settle delay after incoming busy is released
    @(negedge clk);
    master = 1'b0; l_we = 1'b1; l_bi = 1'b0; r_bi = 1'b1;
    @(posedge clk); #1;
    check("R9", "l_wr_ok while busy", l_ok, 1'b0);
    @(negedge clk) l_bi = 1'b1;
    #1;
    check("R9", "l_wr_ok before settle edge", l_ok, 1'b0);
    @(posedge clk); #1;
    check("R9", "l_wr_ok after settle edge", l_ok, 1'b1);

    // R10: reset in mid-contention releases busy asynchronously
    @(negedge clk);
    master = 1'b1; l_ce = 1'b1; r_ce = 1'b1; l_addr = 4'd15; r_addr = 4'd15;
    l_we = 1'b0; r_we = 1'b0;
    @(posedge clk); #1;
    check("R10", "r_busy before reset", r_bo, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    check("R10", "r_busy on reset", r_bo, 1'b1);
    check("R10", "l_busy on reset", l_bo, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R3: both arrive as fresh after reset, left wins
    check("R3", "r_busy after reset", r_bo, 1'b0);

    finish_run();
  end
endmodule